// File: doc/BRIEF.md
# Segmented Virtual Effective Address Generator

This block turns one memory-reference instruction word of a 16-bit segmented machine into a 32-bit virtual address: segment in the upper half, word in the lower half. A start pulse hands it the instruction. While it works, the block reads the program counter, the X and Y index registers, four base registers and a live-register limit from its inputs. It recognises a two-word long form and several one-word short forms: direct, link-base relative, stack-base relative, PC-relative, and sector zero with optional indirection.

All fetches use one read port with a request/acknowledge handshake. These are the displacement word of the long form, the two-word pointer of long indirection, and the single indirect word of the short forms. A register-file read uses the same port, with address bit 31 set. At the end the block gives a one-cycle done pulse with the address, a flag for a register-file reference, and a pointer-fault flag with the offending pointer word.

Top module: `vea_gen`

## Requirements
- R1: While reset is held and directly after it, done, fault, pc_step and mem_req are low.
- R2: The long form is recognised when instruction bits 9:8 are 11 and bits 7:5 are 000. It issues one read at {pc_seg, pc_word} for a displacement and gives one pc_step pulse. Bits 1:0 pick base register 0 to 3, where 1 is the stack base and 2 is the link base. The result segment is that base segment OR-ed with the ring bits (pc_seg bits 14:13). The result word is the base word plus the displacement.
- R3: The effective index flag is bit 14, forced to 0 when bits 13:10 equal 1101. In the long form, the 3-bit code {bit 15, effective index, bit 4} adds X before indirection for codes 2 and 6, and Y for codes 1 and 4. Neither is added when bits 13:10 equal 1101.
- R4: For long codes 3 to 7, a pointer is read at the computed address and then at word+1 in the same segment. The result segment is the first word OR the ring bits, and the result word is the second word. Afterwards X is added for code 7 and Y for code 5, unless bits 13:10 equal 1101.
- R5: If bit 15 of the first pointer word is set, the block issues no further read. Its done pulse carries fault=1, fault_word set to that word, and ea set to the pointer address. Otherwise fault is 0 and fault_word is 0.
- R6: Short direct form (bits 15 and 9 both 0): the offset is bits 8:0, plus X when the effective index flag is set. If bit 8 is set, the result is {link base segment OR ring, link base word + offset}.
- R7: In short direct with bit 8 clear, an offset at or above live_lim gives {stack base segment OR ring, stack base word + offset}. Below live_lim it gives a register reference {1, pc_seg[14:0], offset} with ea_is_reg=1.
- R8: The other short forms with bit 9 set are PC-relative: word = pc_word + sign-extended bits 8:0. Any final short word at or above live_lim gives {pc_seg, word}. Below live_lim it gives a register reference.
- R9: Sector zero (bit 15 set, bit 9 clear): the word is bits 8:0. If it is below 64 and the effective index flag is set, X is added first and no post-index follows.
- R10: In the non-direct short forms, bit 15 requests indirection. A word at or above live_lim is replaced by the memory word at {pc_seg, word}. Otherwise it is replaced by the register-file word read at {1, pc_seg[14:0], word}. X is then added if the index flag is still in force.
- R11: Every word addition wraps modulo 2^16 and never carries into the segment.
- R12: At most one read is outstanding. mem_req stays high with a stable mem_addr until mem_ack, each mem_ack completes one read, and done lasts one cycle with mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one address computation (idle only) |
| instr | input | 16 | Instruction word |
| pc_seg | input | 16 | Program counter segment |
| pc_word | input | 16 | Program counter word |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| base_seg | input | 4x16 | Base register segments |
| base_word | input | 4x16 | Base register words |
| live_lim | input | 16 | Live-register window limit |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address (bit 31 set: register file) |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| pc_step | output | 1 | Program counter advance pulse |
| done | output | 1 | Result valid pulse |
| ea | output | 32 | Effective address or faulting pointer address |
| ea_is_reg | output | 1 | Result is a register-file reference |
| fault | output | 1 | Pointer fault |
| fault_word | output | 16 | Faulting pointer word |

## Verification
The assertions assume that the read responder never acknowledges unless a request is pending. They also assume that start arrives only while the block is idle, and that the register, base and limit inputs stay stable from start to done. The bench holds all operand inputs between operations and sends start only after the previous done. Its responder gives at most one acknowledge per request, with variable stalls, and the bench checks that the number of reads matches the expected count.

// File: rtl/vea_pkg.sv
package vea_pkg;
  localparam int unsigned WW      = 16;
  localparam int unsigned NBASE   = 4;
  localparam int unsigned SELW    = $clog2(NBASE);
  localparam int unsigned RING_LO = 13;
  localparam int unsigned RING_HI = 14;
  localparam int unsigned SB_SEL  = 1;
  localparam int unsigned LB_SEL  = 2;
  localparam int unsigned AW      = 2 * WW;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DISP,
    S_PTR0,
    S_PTR1,
    S_IND
  } vea_state_e;

  typedef struct packed {
    logic            long_form;
    logic            direct;
    logic            lb_rel;
    logic            indirect;
    logic            preidx;
    logic            short_post_x;
    logic            pcrel;
    logic            pre_x;
    logic            pre_y;
    logic            post_x;
    logic            post_y;
    logic            ptr;
    logic [SELW-1:0] sel;
  } vea_dec_t;
endpackage

// File: rtl/vea_decode.sv
module vea_decode
  import vea_pkg::*;
(
  input  logic [WW-1:0] instr,
  output vea_dec_t      dec
);
  logic       idx_ok;
  logic       idx;
  logic [2:0] code;
  logic       sector0;

  always_comb begin
    idx_ok  = (instr[13:10] != 4'b1101);
    idx     = instr[14] & idx_ok;
    code    = {instr[15], idx, instr[4]};
    sector0 = 1'b0;

    dec.long_form    = (instr[9:5] == 5'b11000);
    dec.sel          = instr[SELW-1:0];
    dec.pre_x        = idx_ok && (code == 3'd2 || code == 3'd6);
    dec.pre_y        = idx_ok && (code == 3'd1 || code == 3'd4);
    dec.post_x       = idx_ok && (code == 3'd7);
    dec.post_y       = idx_ok && (code == 3'd5);
    dec.ptr          = (code >= 3'd3);

    dec.direct       = !dec.long_form && !instr[15] && !instr[9];
    dec.lb_rel       = instr[8];
    dec.pcrel        = !dec.long_form && !dec.direct && instr[9];
    sector0          = !dec.long_form && !dec.direct && !instr[9];
    dec.preidx       = sector0 && idx && (instr[8:6] == 3'b000);
    dec.indirect     = !dec.long_form && !dec.direct && instr[15];
    dec.short_post_x = !dec.direct && idx && !dec.preidx;
  end
endmodule

// File: rtl/vea_short_addr.sv
module vea_short_addr
  import vea_pkg::*;
(
  input  logic [WW-1:0] instr,
  input  vea_dec_t      dec,
  input  logic [WW-1:0] pc_word,
  input  logic [WW-1:0] x_reg,
  output logic [WW-1:0] w0
);
  localparam int unsigned OFFW = 9;

  logic [WW-1:0] off_z;
  logic [WW-1:0] off_s;
  logic          idx;

  always_comb begin
    off_z = {{(WW-OFFW){1'b0}}, instr[OFFW-1:0]};
    off_s = {{(WW-OFFW){instr[OFFW-1]}}, instr[OFFW-1:0]};
    idx   = instr[14] && (instr[13:10] != 4'b1101);
    if (dec.direct)
      w0 = off_z + (idx ? x_reg : '0);
    else if (dec.pcrel)
      w0 = pc_word + off_s;
    else
      w0 = off_z + (dec.preidx ? x_reg : '0);
  end
endmodule

// File: rtl/vea_base_mux.sv
module vea_base_mux
  import vea_pkg::*;
(
  input  logic [NBASE-1:0][WW-1:0] base_seg,
  input  logic [NBASE-1:0][WW-1:0] base_word,
  input  logic [WW-1:0]            ring,
  input  logic [SELW-1:0]          sel,
  output logic [WW-1:0]            sel_seg,
  output logic [WW-1:0]            sel_word
);
  logic [NBASE-1:0][WW-1:0] seg_or;

  for (genvar g = 0; g < NBASE; g++) begin : g_base
    assign seg_or[g] = base_seg[g] | ring;
  end

  assign sel_seg  = seg_or[sel];
  assign sel_word = base_word[sel];
endmodule

// File: rtl/vea_seq.sv
module vea_seq
  import vea_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  vea_dec_t        dec,
  input  logic [WW-1:0]   w0,
  input  logic [WW-1:0]   pc_seg,
  input  logic [WW-1:0]   pc_word,
  input  logic [WW-1:0]   x_reg,
  input  logic [WW-1:0]   y_reg,
  input  logic [WW-1:0]   live_lim,
  input  logic [WW-1:0]   ring,
  input  logic [WW-1:0]   sel_seg,
  input  logic [WW-1:0]   sel_word,
  output logic [SELW-1:0] base_sel,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [WW-1:0]   mem_rdata,
  output logic            pc_step,
  output logic            done,
  output logic [AW-1:0]   ea,
  output logic            ea_is_reg,
  output logic            fault,
  output logic [WW-1:0]   fault_word
);
  vea_state_e    st, st_n;
  vea_dec_t      dq, dq_n;
  logic [WW-1:0] seg_q, seg_n;
  logic          req_n, step_n, done_n, reg_n, flt_n;
  logic [AW-1:0] addr_n, ea_n;
  logic [WW-1:0] fw_n;
  logic [WW-1:0] wtmp;
  logic          upd;

  function automatic logic [AW-1:0] reg_ref(input logic [WW-1:0] seg,
                                            input logic [WW-1:0] w);
    return {1'b1, seg[WW-2:0], w};
  endfunction

  assign base_sel = (st == S_IDLE) ? (dec.lb_rel ? SELW'(LB_SEL) : SELW'(SB_SEL))
                                   : dq.sel;

  always_comb begin
    st_n   = st;
    dq_n   = dq;
    seg_n  = seg_q;
    req_n  = mem_req;
    addr_n = mem_addr;
    step_n = 1'b0;
    done_n = 1'b0;
    ea_n   = ea;
    reg_n  = ea_is_reg;
    flt_n  = fault;
    fw_n   = fault_word;
    wtmp   = '0;
    case (st)
      S_IDLE: begin
        if (start) begin
          dq_n  = dec;
          flt_n = 1'b0;
          fw_n  = '0;
          reg_n = 1'b0;
          if (dec.long_form) begin
            req_n  = 1'b1;
            addr_n = {pc_seg, pc_word};
            st_n   = S_DISP;
          end else if (dec.direct) begin
            done_n = 1'b1;
            if (dec.lb_rel || w0 >= live_lim) begin
              ea_n = {sel_seg, sel_word + w0};
            end else begin
              ea_n  = reg_ref(pc_seg, w0);
              reg_n = 1'b1;
            end
          end else if (dec.indirect) begin
            req_n  = 1'b1;
            addr_n = (w0 >= live_lim) ? {pc_seg, w0} : reg_ref(pc_seg, w0);
            st_n   = S_IND;
          end else begin
            done_n = 1'b1;
            wtmp   = w0 + (dec.short_post_x ? x_reg : '0);
            if (wtmp >= live_lim) begin
              ea_n = {pc_seg, wtmp};
            end else begin
              ea_n  = reg_ref(pc_seg, wtmp);
              reg_n = 1'b1;
            end
          end
        end
      end
      S_IND: begin
        if (mem_ack) begin
          req_n  = 1'b0;
          done_n = 1'b1;
          st_n   = S_IDLE;
          wtmp   = mem_rdata + (dq.short_post_x ? x_reg : '0);
          if (wtmp >= live_lim) begin
            ea_n = {pc_seg, wtmp};
          end else begin
            ea_n  = reg_ref(pc_seg, wtmp);
            reg_n = 1'b1;
          end
        end
      end
      S_DISP: begin
        if (mem_ack) begin
          step_n = 1'b1;
          wtmp   = sel_word + mem_rdata + (dq.pre_x ? x_reg : '0)
                                        + (dq.pre_y ? y_reg : '0);
          if (dq.ptr) begin
            addr_n = {sel_seg, wtmp};
            st_n   = S_PTR0;
          end else begin
            req_n  = 1'b0;
            done_n = 1'b1;
            ea_n   = {sel_seg, wtmp};
            st_n   = S_IDLE;
          end
        end
      end
      S_PTR0: begin
        if (mem_ack) begin
          if (mem_rdata[WW-1]) begin
            req_n  = 1'b0;
            done_n = 1'b1;
            flt_n  = 1'b1;
            fw_n   = mem_rdata;
            ea_n   = mem_addr;
            st_n   = S_IDLE;
          end else begin
            seg_n  = mem_rdata | ring;
            wtmp   = mem_addr[WW-1:0] + WW'(1);
            addr_n = {mem_addr[AW-1:WW], wtmp};
            st_n   = S_PTR1;
          end
        end
      end
      S_PTR1: begin
        if (mem_ack) begin
          req_n  = 1'b0;
          done_n = 1'b1;
          wtmp   = mem_rdata + (dq.post_x ? x_reg : '0) + (dq.post_y ? y_reg : '0);
          ea_n   = {seg_q, wtmp};
          st_n   = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  assign upd = (st != S_IDLE) ? mem_ack : start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mem_req <= 1'b0;
      pc_step <= 1'b0;
      done    <= 1'b0;
    end else begin
      st      <= st_n;
      mem_req <= req_n;
      pc_step <= step_n;
      done    <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq         <= '0;
      seg_q      <= '0;
      mem_addr   <= '0;
      ea         <= '0;
      ea_is_reg  <= 1'b0;
      fault      <= 1'b0;
      fault_word <= '0;
    end else if (upd) begin
      dq         <= dq_n;
      seg_q      <= seg_n;
      mem_addr   <= addr_n;
      ea         <= ea_n;
      ea_is_reg  <= reg_n;
      fault      <= flt_n;
      fault_word <= fw_n;
    end
  end

  // R12: request held with a stable address until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: no read pending when a result is presented
  a_r12_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  // R5: after a pointer fault no further read is issued
  a_r5_fault_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |=> !mem_req);

  // R2: the program counter advance is a single pulse
  a_r2_step_once: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> !pc_step);

  // R7: a register reference carries address bit 31
  a_r7_regref_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ea_is_reg) |-> ea[AW-1]);

  // R1: quiet outputs in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!done && !mem_req && !pc_step));
endmodule

// File: rtl/vea_gen.sv
module vea_gen
  import vea_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [WW-1:0]            instr,
  input  logic [WW-1:0]            pc_seg,
  input  logic [WW-1:0]            pc_word,
  input  logic [WW-1:0]            x_reg,
  input  logic [WW-1:0]            y_reg,
  input  logic [NBASE-1:0][WW-1:0] base_seg,
  input  logic [NBASE-1:0][WW-1:0] base_word,
  input  logic [WW-1:0]            live_lim,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_ack,
  input  logic [WW-1:0]            mem_rdata,
  output logic                     pc_step,
  output logic                     done,
  output logic [AW-1:0]            ea,
  output logic                     ea_is_reg,
  output logic                     fault,
  output logic [WW-1:0]            fault_word
);
  vea_dec_t        dec;
  logic [WW-1:0]   w0;
  logic [WW-1:0]   ring;
  logic [SELW-1:0] base_sel;
  logic [WW-1:0]   sel_seg;
  logic [WW-1:0]   sel_word;

  always_comb begin
    ring                   = '0;
    ring[RING_HI:RING_LO]  = pc_seg[RING_HI:RING_LO];
  end

  vea_decode i_dec (
    .instr (instr),
    .dec   (dec)
  );

  vea_short_addr i_short (
    .instr   (instr),
    .dec     (dec),
    .pc_word (pc_word),
    .x_reg   (x_reg),
    .w0      (w0)
  );

  vea_base_mux i_base (
    .base_seg  (base_seg),
    .base_word (base_word),
    .ring      (ring),
    .sel       (base_sel),
    .sel_seg   (sel_seg),
    .sel_word  (sel_word)
  );

  vea_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dec        (dec),
    .w0         (w0),
    .pc_seg     (pc_seg),
    .pc_word    (pc_word),
    .x_reg      (x_reg),
    .y_reg      (y_reg),
    .live_lim   (live_lim),
    .ring       (ring),
    .sel_seg    (sel_seg),
    .sel_word   (sel_word),
    .base_sel   (base_sel),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .pc_step    (pc_step),
    .done       (done),
    .ea         (ea),
    .ea_is_reg  (ea_is_reg),
    .fault      (fault),
    .fault_word (fault_word)
  );
endmodule

// File: tb/test_vea_gen.sv
`timescale 1ns/1ps
module test_vea_gen;
  logic             clk;
  logic             rst_n;
  logic             start;
  logic [15:0]      instr;
  logic [15:0]      pc_seg, pc_word, xr, yr, lim;
  logic [3:0][15:0] bseg, bword;
  logic             mem_req, mem_ack, pc_step, done, ea_is_reg, fault;
  logic [31:0]      mem_addr, ea;
  logic [15:0]      mem_rdata, fault_word;

  typedef struct {
    logic [31:0] ea;
    logic        rr;
    logic        flt;
    logic [15:0] fw;
    int          steps;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] ovr[logic [31:0]];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          steps_seen = 0;
  int          reads_seen = 0;
  int          tick = 0;
  bit          finished = 0;

  vea_gen i_vea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .pc_seg(pc_seg), .pc_word(pc_word), .x_reg(xr), .y_reg(yr),
    .base_seg(bseg), .base_word(bword), .live_lim(lim),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pc_step(pc_step), .done(done), .ea(ea),
    .ea_is_reg(ea_is_reg), .fault(fault), .fault_word(fault_word)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [15:0] rd(input logic [31:0] a);
    logic [15:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = (a[15:0] * 16'h9E37) ^ a[31:16] ^ 16'h1357;
    return h & 16'h7FFF;
  endfunction

  function automatic logic [15:0] longi(input bit i, input bit x, input logic [3:0] op,
                                        input bit b4, input logic [1:0] sel);
    return {i, x, op, 5'b11000, b4, 2'b00, sel};
  endfunction

  function automatic logic [15:0] shorti(input bit i, input bit x, input logic [3:0] op,
                                         input bit b9, input logic [8:0] off);
    return {i, x, op, b9, off};
  endfunction

  function automatic exp_t model(input logic [15:0] ins, input string tag);
    exp_t        e;
    logic [15:0] ring, s, w, m, d;
    logic [31:0] pa;
    logic        ok, xe, post;
    logic [2:0]  c;
    ring = pc_seg & 16'h6000;
    ok   = (ins[13:10] != 4'b1101);
    xe   = ins[14] & ok;
    e.rr = 0; e.flt = 0; e.fw = 0; e.steps = 0; e.reads = 0; e.tag = tag;
    if (ins[9:5] == 5'b11000) begin
      e.steps = 1; e.reads = 1;
      d = rd({pc_seg, pc_word});
      c = {ins[15], xe, ins[4]};
      s = bseg[ins[1:0]] | ring;
      w = bword[ins[1:0]] + d;
      if (ok && (c == 3'd2 || c == 3'd6)) w = w + xr;
      else if (ok && (c == 3'd1 || c == 3'd4)) w = w + yr;
      if (c >= 3'd3) begin
        pa = {s, w};
        m  = rd(pa);
        e.reads = 2;
        if (m[15]) begin
          e.flt = 1; e.fw = m; e.ea = pa;
          return e;
        end
        e.reads = 3;
        s = m | ring;
        w = rd({pa[31:16], 16'(pa[15:0] + 16'd1)});
        if (ok && c == 3'd7) w = w + xr;
        else if (ok && c == 3'd5) w = w + yr;
      end
      e.ea = {s, w};
      return e;
    end
    if (!ins[15] && !ins[9]) begin
      w = {7'd0, ins[8:0]} + (xe ? xr : 16'd0);
      if (ins[8]) e.ea = {bseg[2] | ring, 16'(bword[2] + w)};
      else if (w >= lim) e.ea = {bseg[1] | ring, 16'(bword[1] + w)};
      else begin e.ea = {1'b1, pc_seg[14:0], w}; e.rr = 1; end
      return e;
    end
    post = xe;
    if (ins[9]) w = pc_word + {{7{ins[8]}}, ins[8:0]};
    else begin
      w = {7'd0, ins[8:0]};
      if (w < 16'o100 && xe) begin w = w + xr; post = 0; end
    end
    if (ins[15]) begin
      e.reads = 1;
      w = (w >= lim) ? rd({pc_seg, w}) : rd({1'b1, pc_seg[14:0], w});
    end
    if (post) w = w + xr;
    if (w >= lim) e.ea = {pc_seg, w};
    else begin e.ea = {1'b1, pc_seg[14:0], w}; e.rr = 1; end
    return e;
  endfunction

  task automatic run(input logic [15:0] ins, input string tag);
    q.push_back(model(ins, tag));
    @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // memory and register-file responder with stalls
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = 16'h0;
    forever begin
      @(negedge clk);
      tick++;
      if (mem_req && !mem_ack && (tick % 3 != 0)) begin
        mem_ack   = 1'b1;
        mem_rdata = rd(mem_addr);
        reads_seen++;
      end else begin
        mem_ack   = 1'b0;
        mem_rdata = 16'hDEAD;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && pc_step) steps_seen++;
      if (rst_n && done) begin
        n_checks++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R12: unexpected done, ea=%h", ea);
        end else begin
          e = q.pop_front();
          if (ea !== e.ea || ea_is_reg !== e.rr || fault !== e.flt ||
              fault_word !== e.fw || steps_seen != e.steps || reads_seen != e.reads) begin
            n_fail++;
            $display("FAIL %s: ea=%h reg=%b flt=%b fw=%h steps=%0d reads=%0d expected ea=%h reg=%b flt=%b fw=%h steps=%0d reads=%0d",
                     e.tag, ea, ea_is_reg, fault, fault_word, steps_seen, reads_seen,
                     e.ea, e.rr, e.flt, e.fw, e.steps, e.reads);
          end
        end
        steps_seen = 0;
        reads_seen = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    instr   = 16'h0;
    pc_seg  = 16'h4123;
    pc_word = 16'h1000;
    xr      = 16'h0010;
    yr      = 16'h0200;
    lim     = 16'o40;
    bseg    = {16'h0044, 16'h0033, 16'h2022, 16'h0011};
    bword   = {16'hFFF0, 16'h3000, 16'h0800, 16'h0100};
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    n_checks++;
    if (done !== 1'b0 || mem_req !== 1'b0 || pc_step !== 1'b0 || fault !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: done=%b req=%b step=%b fault=%b expected all 0",
               done, mem_req, pc_step, fault);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (done !== 1'b0 || mem_req !== 1'b0 || pc_step !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: after release done=%b req=%b step=%b expected 0", done, mem_req, pc_step);
    end

    // R2: long form, each base register
    run(longi(0, 0, 4'b0010, 0, 2'd0), "R2");
    run(longi(0, 0, 4'b0010, 0, 2'd1), "R2");
    run(longi(0, 0, 4'b0010, 0, 2'd2), "R2");
    ovr[{16'h4123, 16'h1000}] = 16'h0020;
    run(longi(0, 0, 4'b0010, 0, 2'd3), "R11");
    ovr.delete({16'h4123, 16'h1000});
    // R3: pre-index codes
    run(longi(0, 0, 4'b0010, 1, 2'd1), "R3");
    run(longi(0, 1, 4'b0010, 0, 2'd2), "R3");
    run(longi(0, 1, 4'b1101, 1, 2'd0), "R3");
    run(longi(1, 1, 4'b0010, 0, 2'd0), "R3");
    // R4: pointer codes
    run(longi(1, 0, 4'b0010, 0, 2'd1), "R4");
    run(longi(0, 1, 4'b0010, 1, 2'd2), "R4");
    run(longi(1, 0, 4'b0010, 1, 2'd3), "R4");
    run(longi(1, 1, 4'b0010, 1, 2'd0), "R12");
    run(longi(1, 1, 4'b1101, 1, 2'd1), "R4");
    // R5: pointer fault
    pc_word = 16'h2000;
    ovr[{16'h4123, 16'h2000}] = 16'h0050;
    ovr[{16'h4011, 16'h0150}] = 16'h8765;
    run(longi(0, 1, 4'b0010, 1, 2'd0), "R5");
    run(longi(0, 0, 4'b0010, 0, 2'd0), "R5");
    // R6: link-base relative
    run(shorti(0, 0, 4'b0010, 0, 9'o405), "R6");
    run(shorti(0, 1, 4'b0010, 0, 9'o412), "R6");
    // R7: stack-base relative and register window
    run(shorti(0, 0, 4'b0010, 0, 9'o100), "R7");
    run(shorti(0, 0, 4'b0010, 0, 9'o7), "R7");
    run(shorti(0, 1, 4'b0010, 0, 9'o5), "R7");
    run(shorti(0, 1, 4'b1101, 0, 9'o7), "R3");
    // R8: PC-relative
    pc_word = 16'h1000;
    run(shorti(0, 0, 4'b0010, 1, 9'o10), "R8");
    run(shorti(0, 0, 4'b0010, 1, 9'h1F0), "R8");
    run(shorti(0, 1, 4'b0010, 1, 9'o3), "R8");
    pc_word = 16'h0010;
    run(shorti(0, 0, 4'b0010, 1, 9'h1FC), "R8");
    pc_word = 16'h0002;
    run(shorti(0, 0, 4'b0010, 1, 9'h1FC), "R11");
    pc_seg = 16'h2005;
    pc_word = 16'h0400;
    // R9 / R10: sector zero and indirection
    run(shorti(1, 0, 4'b0010, 0, 9'o50), "R10");
    run(shorti(1, 0, 4'b0010, 0, 9'o5), "R10");
    run(shorti(1, 1, 4'b0010, 0, 9'o6), "R9");
    run(shorti(1, 1, 4'b0010, 0, 9'o200), "R9");
    run(shorti(1, 0, 4'b0010, 1, 9'o20), "R10");
    run(shorti(1, 1, 4'b0010, 1, 9'h1E0), "R10");
    run(longi(1, 1, 4'b0010, 1, 2'd2), "R4");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule